// File: doc/BRIEF.md
# Byte ALU with Carry, Digit-Carry and Zero Status

This block is the arithmetic and flag core of a small accumulator controller. In one cycle it combines an 8-bit working value `w_i` with an 8-bit operand `f_i`, which is either a file register or a literal placed there by the caller. It delivers the result on `result_o`. It says whether that result goes back to the working register or to the file operand. It also raises a skip indication for the count-and-skip operations. The result path is purely combinational.

A three-flag status register is held inside the block: carry, digit-carry and zero. An executed operation updates only the flags that it owns, and the block shows which ones on the update-enable outputs. Software can also write the register whole or set and clear single bits. A direct write, then a bit operation, then the operation's own update decide each flag bit, in that order of priority. The register is read as a full byte whose upper five bits are always one.

Subtraction adds the inverted working value plus one to the operand. Carry therefore means "no borrow", and digit-carry means "no borrow out of the low nibble".

Top module: `byte_alu_status`

## Requirements
- R1: After reset, `status_o` reads 8'hF8 (all three flags clear).
- R2: Opcode 2 (add) gives result = (f + W) mod 256. Carry is set when the sum exceeds 255, digit-carry is set when f[3:0] + W[3:0] exceeds 15, and zero is set when the result is 0.
- R3: Opcode 3 (subtract) gives result = (f - W) mod 256. Carry is set when f >= W, digit-carry is set when f[3:0] >= W[3:0], and zero is set when the result is 0.
- R4: Opcode 10 (rotate right through carry) gives {C, f[7:1]} with f[0] going into carry. Opcode 11 (rotate left through carry) gives {f[6:0], C} with f[7] going into carry. Digit-carry and zero keep their values.
- R5: Opcode 12 (nibble swap, {f[3:0], f[7:4]}) and opcode 15 (pass W) change no flag.
- R6: Opcodes 0 (move f), 1 (clear to 0), 4 (AND), 5 (OR), 6 (XOR), 7 (complement f), 8 (f + 1) and 9 (f - 1) update zero only. Carry and digit-carry keep their values.
- R7: Opcodes 13 (f + 1) and 14 (f - 1) raise `skip_o` when exec_i is high and the result is 0, and change no flag. `skip_o` is 0 for every other opcode.
- R8: `status_o` carries carry in bit 0, digit-carry in bit 1 and zero in bit 2; bits 7:3 read as one. With `st_wr_i` high, bits 2:0 of `st_wdata_i` load the flags at the next clock edge.
- R9: A direct status write takes priority over the flag updates of an operation executed in the same cycle.
- R10: `bit_op_i` = 2'b10 sets and 2'b01 clears the flag selected by `bit_sel_i` (0 to 2). Values 3 to 7 of `bit_sel_i`, and `bit_op_i` of 00 or 11, have no effect. A bit operation overrides the operation's update of that same flag only.
- R11: `upd_c_o`, `upd_dc_o` and `upd_z_o` are high exactly when exec_i is high and the opcode affects that flag. With exec_i low the flags hold their values unless written directly or by a bit operation.
- R12: `wr_w_o` = exec_i and not `dest_f_i`, and `wr_f_o` = exec_i and `dest_f_i`. The destination never changes the result or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Executes the operation this cycle |
| op_i | input | 4 | Operation code |
| w_i | input | 8 | Working-register operand |
| f_i | input | 8 | File or literal operand |
| dest_f_i | input | 1 | 1: result to file operand, 0: result to W |
| st_wr_i | input | 1 | Direct status write |
| st_wdata_i | input | 8 | Direct write data (bits 2:0 used) |
| bit_op_i | input | 2 | Status bit operation: 10 set, 01 clear |
| bit_sel_i | input | 3 | Status bit number for bit operation |
| result_o | output | 8 | Operation result |
| skip_o | output | 1 | Skip indication of count-and-skip ops |
| wr_w_o | output | 1 | Result is to be written to W |
| wr_f_o | output | 1 | Result is to be written to the file operand |
| upd_c_o | output | 1 | Carry updated by this operation |
| upd_dc_o | output | 1 | Digit-carry updated by this operation |
| upd_z_o | output | 1 | Zero updated by this operation |
| status_o | output | 8 | Status byte |

## Verification
The hardest situations to reach are the collisions in one cycle: an executed add or subtract that wants to change all three flags while a direct write, or a set or clear of one bit, targets the same register. The stimulus builds exactly those cycles. It pairs a carrying add with a direct write of the opposite values, and a subtract with a clear of only the carry bit, so that the untouched bits still show the operation's update. The nibble and byte borrow edges are reached with operands equal in the low nibble and equal in full. The rotates are run with both carry values so that carry visibly travels through the result.

// File: rtl/byte_alu_status.sv
module byte_alu_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_i,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] w_i,
  input  logic [DW-1:0] f_i,
  input  logic          dest_f_i,
  input  logic          st_wr_i,
  input  logic [DW-1:0] st_wdata_i,
  input  logic [1:0]    bit_op_i,
  input  logic [2:0]    bit_sel_i,
  output logic [DW-1:0] result_o,
  output logic          skip_o,
  output logic          wr_w_o,
  output logic          wr_f_o,
  output logic          upd_c_o,
  output logic          upd_dc_o,
  output logic          upd_z_o,
  output logic [DW-1:0] status_o
);
  localparam int HALF  = DW / 2;
  localparam int NFLAG = 3;

  typedef enum logic [3:0] {
    OP_MOV = 4'd0, OP_CLR = 4'd1, OP_ADD = 4'd2, OP_SUB = 4'd3,
    OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_COM = 4'd7,
    OP_INC = 4'd8, OP_DEC = 4'd9, OP_RRC = 4'd10, OP_RLC = 4'd11,
    OP_SWP = 4'd12, OP_INS = 4'd13, OP_DES = 4'd14, OP_PSW = 4'd15
  } op_t;

  op_t op;
  assign op = op_t'(op_i);

  logic [NFLAG-1:0] flags_q, flags_d, flags_new, flags_upd;

  logic            is_sub;
  logic [DW-1:0]   b_eff;
  logic [DW:0]     sum;
  logic [HALF:0]   lo_sum;

  assign is_sub = (op == OP_SUB);
  assign b_eff  = is_sub ? ~w_i : w_i;
  assign sum    = {1'b0, f_i} + {1'b0, b_eff} + {{DW{1'b0}}, is_sub};
  assign lo_sum = {1'b0, f_i[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, is_sub};

  logic uc, udc, uz, cy_new;

  always_comb begin
    result_o = f_i;
    cy_new   = flags_q[0];
    uc = 1'b0; udc = 1'b0; uz = 1'b0;
    unique case (op)
      OP_MOV: begin result_o = f_i;               uz = 1'b1; end
      OP_CLR: begin result_o = '0;                uz = 1'b1; end
      OP_ADD, OP_SUB: begin
        result_o = sum[DW-1:0];
        cy_new   = sum[DW];
        uc = 1'b1; udc = 1'b1; uz = 1'b1;
      end
      OP_AND: begin result_o = f_i & w_i;         uz = 1'b1; end
      OP_OR:  begin result_o = f_i | w_i;         uz = 1'b1; end
      OP_XOR: begin result_o = f_i ^ w_i;         uz = 1'b1; end
      OP_COM: begin result_o = ~f_i;              uz = 1'b1; end
      OP_INC: begin result_o = f_i + 1'b1;        uz = 1'b1; end
      OP_DEC: begin result_o = f_i - 1'b1;        uz = 1'b1; end
      OP_RRC: begin
        result_o = {flags_q[0], f_i[DW-1:1]};
        cy_new   = f_i[0];
        uc       = 1'b1;
      end
      OP_RLC: begin
        result_o = {f_i[DW-2:0], flags_q[0]};
        cy_new   = f_i[DW-1];
        uc       = 1'b1;
      end
      OP_SWP: result_o = {f_i[HALF-1:0], f_i[DW-1:HALF]};
      OP_INS: result_o = f_i + 1'b1;
      OP_DES: result_o = f_i - 1'b1;
      OP_PSW: result_o = w_i;
      default: result_o = f_i;
    endcase
  end

  assign upd_c_o  = exec_i & uc;
  assign upd_dc_o = exec_i & udc;
  assign upd_z_o  = exec_i & uz;
  assign skip_o   = exec_i & ((op == OP_INS) | (op == OP_DES)) & (result_o == '0);
  assign wr_w_o   = exec_i & ~dest_f_i;
  assign wr_f_o   = exec_i &  dest_f_i;

  assign flags_new = {result_o == '0, lo_sum[HALF], cy_new};
  assign flags_upd = {upd_z_o, upd_dc_o, upd_c_o};

  always_comb begin
    for (int i = 0; i < NFLAG; i++) begin
      if (st_wr_i)
        flags_d[i] = st_wdata_i[i];
      else if ((bit_op_i == 2'b10 || bit_op_i == 2'b01) && bit_sel_i == 3'(i))
        flags_d[i] = bit_op_i[1];
      else if (flags_upd[i])
        flags_d[i] = flags_new[i];
      else
        flags_d[i] = flags_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;

  assign status_o = {{(DW-NFLAG){1'b1}}, flags_q};

  logic inert;
  assign inert = !st_wr_i && (bit_op_i == 2'b00 || bit_op_i == 2'b11);

  AST_DIRECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_i |=> status_o[2:0] == $past(st_wdata_i[2:0])); // R9
  AST_SWAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == 4'd12 && inert) |=> $stable(status_o)); // R5
  AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && (op_i == 4'd4 || op_i == 4'd5 || op_i == 4'd6) && inert)
      |=> status_o[1:0] == $past(status_o[1:0])); // R6
  AST_RRC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == 4'd10 && inert) |=> status_o[0] == $past(f_i[0])); // R4
  AST_INCSKIP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == 4'd13 && f_i == 8'hFF) |-> skip_o); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_i && inert) |=> $stable(status_o)); // R11
endmodule

// File: tb/test_byte_alu_status.sv
module test_byte_alu_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic exec_i = 0, dest_f_i = 0, st_wr_i = 0;
  logic [3:0] op_i = 0;
  logic [7:0] w_i = 0, f_i = 0, st_wdata_i = 0;
  logic [1:0] bit_op_i = 0;
  logic [2:0] bit_sel_i = 0;
  logic [7:0] result_o, status_o;
  logic skip_o, wr_w_o, wr_f_o, upd_c_o, upd_dc_o, upd_z_o;

  always #5 clk = ~clk;

  byte_alu_status i_byte_alu_status (.*);

  typedef struct {
    logic [7:0] res; logic sk, ww, wf, uc, udc, uz;
    logic [7:0] st; string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  logic mc = 0, mdc = 0, mz = 0;
  bit done = 0;

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic pick(input int idx, input logic sw, input logic [7:0] wd,
      input logic [1:0] bo, input logic [2:0] bs, input logic upd, input logic nv, input logic old);
    if (sw) return wd[idx];
    if ((bo == 2'b10 || bo == 2'b01) && bs == 3'(idx)) return bo == 2'b10;
    if (upd) return nv;
    return old;
  endfunction

  task automatic drive(input logic ex, input logic [3:0] op, input logic [7:0] w, input logic [7:0] f,
      input logic d, input logic sw, input logic [7:0] wd, input logic [1:0] bo, input logic [2:0] bs,
      input string tag);
    exp_t e;
    logic c, dc, z, uc, udc, uz, sk;
    logic [7:0] r;
    c = mc; dc = mdc; uc = 0; udc = 0; uz = 0; sk = 0;
    case (op)
      4'd0: begin r = f; uz = 1; end
      4'd1: begin r = 0; uz = 1; end
      4'd2: begin r = f + w; c = (int'(f) + int'(w)) > 255;
                  dc = (int'(f[3:0]) + int'(w[3:0])) > 15; uc = 1; udc = 1; uz = 1; end
      4'd3: begin r = f - w; c = f >= w; dc = f[3:0] >= w[3:0]; uc = 1; udc = 1; uz = 1; end
      4'd4: begin r = f & w; uz = 1; end
      4'd5: begin r = f | w; uz = 1; end
      4'd6: begin r = f ^ w; uz = 1; end
      4'd7: begin r = ~f; uz = 1; end
      4'd8: begin r = f + 8'd1; uz = 1; end
      4'd9: begin r = f - 8'd1; uz = 1; end
      4'd10: begin r = {mc, f[7:1]}; c = f[0]; uc = 1; end
      4'd11: begin r = {f[6:0], mc}; c = f[7]; uc = 1; end
      4'd12: r = {f[3:0], f[7:4]};
      4'd13: begin r = f + 8'd1; sk = (r == 0); end
      4'd14: begin r = f - 8'd1; sk = (r == 0); end
      default: r = w;
    endcase
    z = (r == 0);
    if (!ex) begin uc = 0; udc = 0; uz = 0; sk = 0; end
    mc  = pick(0, sw, wd, bo, bs, uc,  c,  mc);
    mdc = pick(1, sw, wd, bo, bs, udc, dc, mdc);
    mz  = pick(2, sw, wd, bo, bs, uz,  z,  mz);
    e.res = r; e.sk = sk; e.ww = ex & ~d; e.wf = ex & d;
    e.uc = uc; e.udc = udc; e.uz = uz; e.st = {5'b11111, mz, mdc, mc}; e.tag = tag;
    @(negedge clk);
    exec_i = ex; op_i = op; w_i = w; f_i = f; dest_f_i = d;
    st_wr_i = sw; st_wdata_i = wd; bit_op_i = bo; bit_sel_i = bs;
    q.push_back(e);
  endtask

  task automatic op(input logic [3:0] o, input logic [7:0] w, input logic [7:0] f, input string tag);
    drive(1, o, w, f, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        check(result_o == e.res, {e.tag, " result"}, result_o, e.res);
        check(skip_o == e.sk, {e.tag, " skip"}, 8'(skip_o), 8'(e.sk));
        check({wr_w_o, wr_f_o} == {e.ww, e.wf}, {e.tag, " dest"}, 8'({wr_w_o, wr_f_o}), 8'({e.ww, e.wf}));
        check({upd_c_o, upd_dc_o, upd_z_o} == {e.uc, e.udc, e.uz}, {e.tag, " upd"},
              8'({upd_c_o, upd_dc_o, upd_z_o}), 8'({e.uc, e.udc, e.uz}));
        #1;
        check(status_o == e.st, {e.tag, " status"}, status_o, e.st);
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=%h exp=%h", 8'h0, 8'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stimulus
    #12 rst_n = 1;
    #1 check(status_o == 8'hF8, "R1 reset status", status_o, 8'hF8);
    op(4'd2, 8'h0F, 8'h01, "R2 add nibble carry");
    op(4'd2, 8'h80, 8'h80, "R2 add carry zero");
    op(4'd2, 8'h12, 8'h34, "R2 add plain");
    op(4'd3, 8'h05, 8'h05, "R3 sub equal");
    op(4'd3, 8'h01, 8'h10, "R3 sub nibble borrow");
    op(4'd3, 8'h20, 8'h10, "R3 sub borrow");
    drive(1, 4'd2, 8'hFF, 8'h01, 0, 1, 8'h00, 0, 0, "R9 write beats add");
    drive(1, 4'd3, 8'h00, 8'h00, 1, 1, 8'h07, 0, 0, "R9 write beats sub");
    op(4'd10, 8'h00, 8'h02, "R4 rrc carry in");
    op(4'd10, 8'h00, 8'h01, "R4 rrc carry out");
    op(4'd11, 8'h00, 8'h80, "R4 rlc");
    op(4'd11, 8'h00, 8'h00, "R4 rlc carry in");
    op(4'd12, 8'h00, 8'hA5, "R5 swap");
    op(4'd15, 8'h00, 8'h3C, "R5 pass W");
    op(4'd4, 8'hF0, 8'h0F, "R6 and");
    op(4'd5, 8'h00, 8'h00, "R6 or zero");
    op(4'd6, 8'hAA, 8'h55, "R6 xor");
    op(4'd7, 8'h00, 8'hFF, "R6 com");
    op(4'd8, 8'h00, 8'hFF, "R6 inc wrap");
    op(4'd9, 8'h00, 8'h00, "R6 dec wrap");
    op(4'd0, 8'h11, 8'h00, "R6 move");
    op(4'd1, 8'h11, 8'h22, "R6 clear");
    op(4'd13, 8'h00, 8'hFF, "R7 incskip zero");
    op(4'd13, 8'h00, 8'h10, "R7 incskip nonzero");
    op(4'd14, 8'h00, 8'h01, "R7 decskip zero");
    op(4'd14, 8'h00, 8'h00, "R7 decskip wrap");
    drive(0, 4'd14, 8'h00, 8'h01, 0, 0, 0, 0, 0, "R7 R11 idle no skip");
    drive(0, 4'd0, 8'h00, 8'h00, 0, 1, 8'h05, 0, 0, "R8 direct write");
    drive(0, 4'd0, 8'h00, 8'h00, 0, 1, 8'hFA, 0, 0, "R8 upper bits ignored");
    drive(0, 4'd0, 8'h00, 8'h00, 0, 0, 0, 2'b10, 3'd1, "R10 set dc");
    drive(0, 4'd0, 8'h00, 8'h00, 0, 0, 0, 2'b01, 3'd2, "R10 clear z");
    drive(0, 4'd0, 8'h00, 8'h00, 0, 0, 0, 2'b01, 3'd5, "R10 sel out of range");
    drive(0, 4'd0, 8'h00, 8'h00, 0, 0, 0, 2'b11, 3'd1, "R10 inert code");
    drive(1, 4'd3, 8'h01, 8'h02, 0, 0, 0, 2'b01, 3'd0, "R10 clear beats sub carry");
    drive(1, 4'd2, 8'hFF, 8'h01, 0, 0, 0, 2'b10, 3'd2, "R10 set z over add");
    drive(1, 4'd2, 8'h01, 8'h01, 1, 0, 0, 0, 0, "R12 dest file");
    drive(1, 4'd2, 8'h01, 8'h01, 0, 0, 0, 0, 0, "R12 dest W");
    drive(0, 4'd2, 8'hFF, 8'hFF, 0, 0, 0, 0, 0, "R11 idle add");
    drive(0, 4'd0, 8'h00, 8'h00, 0, 0, 0, 0, 0, "R11 idle");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule